// File: doc/BRIEF.md
# Buck Converter Start-Up and Fault Supervisor

This block is the digital sequencer that sits beside the analog loop of a synchronous step-down controller. When the supply-good flag goes high it first runs a short sampling window. During that window it switches on the current source that programs the over-current trip level, and it captures the resulting level code. The captured level is clamped to a ceiling and held. The block then raises the reference step code fed to the error amplifier in 40 equal steps, one step for every 13 switching ticks. After the last step it supervises regulation using the comparator flags.

A flag that the low-side drop exceeds twice the held level is an over-current event. The first such event forces one cycle with switching off and restarts the ramp. The next event latches the converter off. Under-voltage in regulation also latches off. Over-voltage parks the converter with the low-side switch forced on until the feedback falls below the lower hysteresis threshold. A disable request idles the gates and, once released, replays sampling and ramp. Only a supply-good drop clears a latched shutdown.

Top module: `buck_supervisor`

## Requirements
- R1: While `supply_ok` is low, or in the cycle after it falls, `switch_en`, `low_force` and `isrc_en` are 0 and `ref_code` is 0. A supply drop clears `st_latched` and the over-current event count. The first clock edge with `supply_ok` high (and `disable_req` low) starts sampling.
- R2: Sampling keeps `isrc_en` at 1 for exactly SAMPLE_CYCLES (16) clock cycles, with `switch_en` at 0. The ramp then begins with `isrc_en` at 0.
- R3: The held level is the `lvl_code` present in the last sampling cycle. It is forced to LVL_MAX (30) when that code exceeds 30 or `lvl_open` is 1. `oc_limit` equals twice the held level.
- R4: In the ramp, `ref_code` starts at 0 and rises by 1 after every 13 clock edges with `sw_tick` at 1. Edges without a tick leave it unchanged. `switch_en` is 1 during the ramp.
- R5: On the 520th tick edge of the ramp, `ref_code` reaches 40 and `st_ready` rises. Both stay at these values while regulation continues.
- R6: The first `oc_trip` seen during ramp or regulation gives one cycle with `switch_en` at 0 and `st_ready` at 0. The ramp then restarts from 0 without a new sampling window.
- R7: The second `oc_trip` since the supply rose sets `st_latched`, with `switch_en` and `low_force` at 0. Disable, over-voltage or other flags do not change this. Only a supply drop clears it.
- R8: `uv_trip` during regulation sets `st_latched`. If `uv_trip` and `oc_trip` arrive in the same cycle, the latch wins over the over-current retry.
- R9: `uv_trip` during the ramp is ignored: no latch, and the ramp keeps counting.
- R10: `ov_above` during ramp or regulation sets `st_ov` with `low_force` 1 and `switch_en` 0 on the next edge. This holds until an edge with `ov_below` at 1, after which normal switching resumes.
- R11: While `disable_req` is 1 (and no latch is set), `switch_en`, `low_force` and `ref_code` are 0. Releasing it starts a new sampling window, then the ramp. The over-current event count is kept across a disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above power-on threshold |
| disable_req | input | 1 | External shutdown request |
| sw_tick | input | 1 | One pulse per switching period |
| oc_trip | input | 1 | Low-side drop above `oc_limit` |
| uv_trip | input | 1 | Feedback below half reference |
| ov_above | input | 1 | Feedback above upper over-voltage threshold |
| ov_below | input | 1 | Feedback below lower over-voltage threshold |
| lvl_code | input | 6 | Digitised trip level seen during sampling |
| lvl_open | input | 1 | Trip-level resistor absent |
| ref_code | output | 6 | Reference step code, 40 = full scale |
| isrc_en | output | 1 | Trip-level current source enable |
| oc_limit | output | 7 | Over-current comparator threshold (2x held level) |
| switch_en | output | 1 | Normal switching permitted |
| low_force | output | 1 | Force low-side switch on |
| st_ready | output | 1 | Ramp complete, regulating |
| st_latched | output | 1 | Latched fault shutdown |
| st_ov | output | 1 | Over-voltage clamp active |

## Verification
During regulation, the under-voltage latch and the over-current retry can both be triggered on one clock edge. The bench provokes this right after a fresh power cycle, when the event count is zero and an over-current alone would only retry. It raises `uv_trip` and `oc_trip` together for a single edge. A set `st_latched`, rather than a retry, shows that the latch took priority.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    typedef enum logic [2:0] {
        ST_POR,
        ST_SAMPLE,
        ST_RAMP,
        ST_RUN,
        ST_RETRY,
        ST_OFF,
        ST_LATCH
    } seq_state_t;

    typedef struct packed {
        logic oc;
        logic uv;
        logic ov_above;
        logic ov_below;
    } fault_flags_t;

    localparam int DEF_NUM_STEPS      = 40;
    localparam int DEF_TICKS_PER_STEP = 13;
    localparam int DEF_SAMPLE_CYCLES  = 16;
    localparam int DEF_LVL_W          = 6;
    localparam int DEF_LVL_MAX        = 30;
    localparam int DEF_OC_LIMIT       = 2;

    function automatic int unsigned clamp_level(input int unsigned code,
                                                input logic        open_in,
                                                input int unsigned lmax);
        if (open_in || code > lmax)
            return lmax;
        return code;
    endfunction

    function automatic logic is_powered(input seq_state_t st);
        return (st == ST_RAMP) || (st == ST_RUN);
    endfunction

endpackage

// File: rtl/buck_seq_sampler.sv
module buck_seq_sampler
    import buck_seq_pkg::*;
#(
    parameter int SAMPLE_CYCLES = DEF_SAMPLE_CYCLES,
    parameter int LVL_W         = DEF_LVL_W,
    parameter int LVL_MAX       = DEF_LVL_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [LVL_W-1:0] lvl_code,
    input  logic             lvl_open,
    output logic             done,
    output logic [LVL_W-1:0] held
);
    localparam int CNT_W = $clog2(SAMPLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign done = active && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            held <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (done) begin
            cnt  <= '0;
            held <= LVL_W'(clamp_level(32'(lvl_code), lvl_open, LVL_MAX));
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: held trip level never exceeds the ceiling
    assert_level_cap_R3: assert property (@(posedge clk) disable iff (rst)
        active |-> (held <= LVL_W'(LVL_MAX)));

    // R2: a window only completes while still active
    assert_window_active_R2: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt == '0));

endmodule

// File: rtl/buck_seq_ramp.sv
module buck_seq_ramp
    import buck_seq_pkg::*;
#(
    parameter int NUM_STEPS      = DEF_NUM_STEPS,
    parameter int TICKS_PER_STEP = DEF_TICKS_PER_STEP,
    parameter int STEP_W         = $clog2(NUM_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    output logic [STEP_W-1:0] step,
    output logic              done
);
    localparam int TICK_W = $clog2(TICKS_PER_STEP + 1);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_STEP - 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    logic [TICK_W-1:0] tcnt;
    logic              step_edge;

    assign step_edge = run && tick && (tcnt == LAST_TICK);
    assign done      = step_edge && (step == LAST_STEP);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tcnt <= '0;
            step <= '0;
        end else if (tick) begin
            if (step_edge) begin
                tcnt <= '0;
                step <= step + 1'b1;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // R4: the step code never falls while the ramp keeps running
    assert_step_monotone_R4: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> (step >= $past(step)));

    // R4: edges without a tick leave the step unchanged
    assert_no_tick_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(tick)) |-> $stable(step));

    // R5: the step code never passes full scale
    assert_step_bound_R5: assert property (@(posedge clk) disable iff (rst)
        step <= STEP_W'(NUM_STEPS));

endmodule

// File: rtl/buck_seq_supervisor.sv
module buck_seq_supervisor
    import buck_seq_pkg::*;
#(
    parameter int OC_LIMIT = DEF_OC_LIMIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         supply_ok,
    input  logic         disable_req,
    input  fault_flags_t flags,
    input  logic         samp_done,
    input  logic         ramp_done,
    output seq_state_t   state,
    output logic         ov_active
);
    localparam int OC_W = $clog2(OC_LIMIT + 1);
    localparam logic [OC_W-1:0] OC_LAST = OC_W'(OC_LIMIT - 1);

    seq_state_t      nxt;
    logic [OC_W-1:0] oc_cnt;
    logic [OC_W-1:0] oc_cnt_nxt;
    logic            oc_event;

    assign oc_event = flags.oc && is_powered(state);

    always_comb begin
        nxt        = state;
        oc_cnt_nxt = oc_cnt;
        if (!supply_ok) begin
            nxt        = ST_POR;
            oc_cnt_nxt = '0;
        end else if (state == ST_LATCH) begin
            nxt = ST_LATCH;
        end else if (disable_req) begin
            nxt = ST_OFF;
        end else begin
            case (state)
                ST_POR, ST_OFF: nxt = ST_SAMPLE;
                ST_SAMPLE:      if (samp_done) nxt = ST_RAMP;
                ST_RETRY:       nxt = ST_RAMP;
                ST_RAMP, ST_RUN: begin
                    if (state == ST_RUN && flags.uv) begin
                        nxt = ST_LATCH;
                    end else if (oc_event) begin
                        if (oc_cnt >= OC_LAST) begin
                            nxt = ST_LATCH;
                        end else begin
                            nxt        = ST_RETRY;
                            oc_cnt_nxt = oc_cnt + 1'b1;
                        end
                    end else if (state == ST_RAMP && ramp_done) begin
                        nxt = ST_RUN;
                    end
                end
                default: nxt = ST_POR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_POR;
            oc_cnt <= '0;
        end else begin
            state  <= nxt;
            oc_cnt <= oc_cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !is_powered(nxt)) begin
            ov_active <= 1'b0;
        end else if (ov_active) begin
            if (flags.ov_below) ov_active <= 1'b0;
        end else if (flags.ov_above) begin
            ov_active <= 1'b1;
        end
    end

    // R1: a supply drop always returns the sequencer to its idle state
    assert_supply_drop_R1: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (state == ST_POR));

    // R7: a latched shutdown persists while the supply stays good
    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCH && supply_ok) |=> (state == ST_LATCH));

    // R9: under-voltage during the ramp never latches
    assert_uv_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RAMP && flags.uv && !flags.oc && supply_ok && !disable_req)
        |=> (state != ST_LATCH));

    // R10: over-voltage while regulating engages the clamp next cycle
    assert_ov_enter_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && flags.ov_above && !flags.uv && !flags.oc &&
         supply_ok && !disable_req) |=> ov_active);

    // R8: under-voltage in regulation wins over an over-current retry
    assert_uv_priority_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && flags.uv && supply_ok) |=> (state == ST_LATCH));

endmodule

// File: rtl/buck_supervisor.sv
module buck_supervisor
    import buck_seq_pkg::*;
#(
    parameter int NUM_STEPS      = DEF_NUM_STEPS,
    parameter int TICKS_PER_STEP = DEF_TICKS_PER_STEP,
    parameter int SAMPLE_CYCLES  = DEF_SAMPLE_CYCLES,
    parameter int LVL_W          = DEF_LVL_W,
    parameter int LVL_MAX        = DEF_LVL_MAX,
    parameter int OC_LIMIT       = DEF_OC_LIMIT,
    parameter int STEP_W         = $clog2(NUM_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic              disable_req,
    input  logic              sw_tick,
    input  logic              oc_trip,
    input  logic              uv_trip,
    input  logic              ov_above,
    input  logic              ov_below,
    input  logic [LVL_W-1:0]  lvl_code,
    input  logic              lvl_open,
    output logic [STEP_W-1:0] ref_code,
    output logic              isrc_en,
    output logic [LVL_W:0]    oc_limit,
    output logic              switch_en,
    output logic              low_force,
    output logic              st_ready,
    output logic              st_latched,
    output logic              st_ov
);
    localparam logic [STEP_W-1:0] FULL_SCALE = STEP_W'(NUM_STEPS);

    seq_state_t        state;
    fault_flags_t      flags;
    logic              ov_active;
    logic              samp_done;
    logic              ramp_done;
    logic [STEP_W-1:0] step;
    logic [LVL_W-1:0]  held;
    logic              powered;

    assign flags = '{oc: oc_trip, uv: uv_trip, ov_above: ov_above, ov_below: ov_below};

    buck_seq_supervisor #(
        .OC_LIMIT (OC_LIMIT)
    ) u_sup (
        .clk         (clk),
        .rst         (rst),
        .supply_ok   (supply_ok),
        .disable_req (disable_req),
        .flags       (flags),
        .samp_done   (samp_done),
        .ramp_done   (ramp_done),
        .state       (state),
        .ov_active   (ov_active)
    );

    buck_seq_sampler #(
        .SAMPLE_CYCLES (SAMPLE_CYCLES),
        .LVL_W         (LVL_W),
        .LVL_MAX       (LVL_MAX)
    ) u_samp (
        .clk      (clk),
        .rst      (rst),
        .active   (state == ST_SAMPLE),
        .lvl_code (lvl_code),
        .lvl_open (lvl_open),
        .done     (samp_done),
        .held     (held)
    );

    buck_seq_ramp #(
        .NUM_STEPS      (NUM_STEPS),
        .TICKS_PER_STEP (TICKS_PER_STEP),
        .STEP_W         (STEP_W)
    ) u_ramp (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_RAMP),
        .tick (sw_tick),
        .step (step),
        .done (ramp_done)
    );

    assign powered    = is_powered(state);
    assign isrc_en    = (state == ST_SAMPLE);
    assign switch_en  = powered && !ov_active;
    assign low_force  = powered && ov_active;
    assign st_ready   = (state == ST_RUN);
    assign st_latched = (state == ST_LATCH);
    assign st_ov      = ov_active;
    assign oc_limit   = {held, 1'b0};

    always_comb begin
        case (state)
            ST_RAMP: ref_code = step;
            ST_RUN:  ref_code = FULL_SCALE;
            default: ref_code = '0;
        endcase
    end

    // R2: the sampling source never overlaps switching or a nonzero reference
    assert_isrc_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        isrc_en |-> (!switch_en && !low_force && ref_code == '0));

    // R10: the two gate commands are never both asserted
    assert_gates_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(switch_en && low_force));

    // R7: latched shutdown keeps both gate commands off
    assert_latch_gates_off_R7: assert property (@(posedge clk) disable iff (rst)
        st_latched |-> (!switch_en && !low_force));

    // R5: readiness only ever shows the full-scale reference
    assert_ready_full_R5: assert property (@(posedge clk) disable iff (rst)
        st_ready |-> (ref_code == FULL_SCALE));

endmodule

// File: tb/tb_buck_supervisor.sv
module tb_buck_supervisor;

    logic       clk = 1'b0;
    logic       rst;
    logic       supply_ok, disable_req, sw_tick;
    logic       oc_trip, uv_trip, ov_above, ov_below;
    logic [5:0] lvl_code;
    logic       lvl_open;
    logic [5:0] ref_code;
    logic       isrc_en;
    logic [6:0] oc_limit;
    logic       switch_en, low_force, st_ready, st_latched, st_ov;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    buck_supervisor dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .disable_req(disable_req),
        .sw_tick(sw_tick), .oc_trip(oc_trip), .uv_trip(uv_trip),
        .ov_above(ov_above), .ov_below(ov_below), .lvl_code(lvl_code),
        .lvl_open(lvl_open), .ref_code(ref_code), .isrc_en(isrc_en),
        .oc_limit(oc_limit), .switch_en(switch_en), .low_force(low_force),
        .st_ready(st_ready), .st_latched(st_latched), .st_ov(st_ov)
    );

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic power_up(input int lvl, input bit open_in);
        supply_ok = 1'b0;
        adv(2);
        lvl_code  = 6'(lvl);
        lvl_open  = open_in;
        sw_tick   = 1'b1;
        supply_ok = 1'b1;
        adv(17 + 520);
        chk("R5", "ready after bring-up", int'(st_ready), 1);
    endtask

    task automatic t_reset;
        chk("R1", "ref after reset", int'(ref_code), 0);
        chk("R1", "isrc after reset", int'(isrc_en), 0);
        chk("R1", "switch after reset", int'(switch_en), 0);
        chk("R1", "low_force after reset", int'(low_force), 0);
        chk("R1", "latched after reset", int'(st_latched), 0);
        chk("R1", "ready after reset", int'(st_ready), 0);
    endtask

    task automatic t_sample_and_ramp;
        lvl_code = 6'd20; lvl_open = 1'b0; sw_tick = 1'b0;
        supply_ok = 1'b1;
        adv(1);
        chk("R1", "sampling starts one edge after supply", int'(isrc_en), 1);
        chk("R2", "no switching while sampling", int'(switch_en), 0);
        adv(15);
        chk("R2", "isrc in 16th sampling cycle", int'(isrc_en), 1);
        adv(1);
        chk("R2", "isrc off after window", int'(isrc_en), 0);
        chk("R4", "switching on in ramp", int'(switch_en), 1);
        chk("R3", "oc_limit is twice level", int'(oc_limit), 40);
        adv(5);
        chk("R4", "no ticks keep step", int'(ref_code), 0);
        sw_tick = 1'b1;
        adv(12);
        chk("R4", "step before 13th tick", int'(ref_code), 0);
        adv(1);
        chk("R4", "step after 13th tick", int'(ref_code), 1);
        adv(100);
        uv_trip = 1'b1;
        adv(1);
        uv_trip = 1'b0;
        chk("R9", "uv in ramp no latch", int'(st_latched), 0);
        chk("R9", "uv in ramp keeps switching", int'(switch_en), 1);
        chk("R9", "ramp keeps counting", int'(ref_code), 8);
        adv(405);
        chk("R5", "step before last tick", int'(ref_code), 39);
        chk("R5", "not ready before last tick", int'(st_ready), 0);
        adv(1);
        chk("R5", "full scale", int'(ref_code), 40);
        chk("R5", "ready", int'(st_ready), 1);
        adv(20);
        chk("R5", "full scale holds", int'(ref_code), 40);
    endtask

    task automatic t_clamp;
        power_up(45, 1'b0);
        chk("R3", "code above max clamps", int'(oc_limit), 60);
        power_up(5, 1'b1);
        chk("R3", "open input clamps", int'(oc_limit), 60);
        power_up(29, 1'b0);
        chk("R3", "code below max kept", int'(oc_limit), 58);
    endtask

    task automatic t_oc_retry_latch;
        power_up(20, 1'b0);
        oc_trip = 1'b1; adv(1); oc_trip = 1'b0;
        chk("R6", "switch off after first oc", int'(switch_en), 0);
        chk("R6", "not ready after first oc", int'(st_ready), 0);
        chk("R6", "no latch after first oc", int'(st_latched), 0);
        adv(1);
        chk("R6", "ramp restarted switching", int'(switch_en), 1);
        chk("R6", "ramp restarted at zero", int'(ref_code), 0);
        chk("R6", "no resampling", int'(isrc_en), 0);
        adv(26);
        chk("R6", "restarted ramp counts", int'(ref_code), 2);
        oc_trip = 1'b1; adv(1); oc_trip = 1'b0;
        chk("R7", "second oc latches", int'(st_latched), 1);
        chk("R7", "latched switch off", int'(switch_en), 0);
        chk("R7", "latched low off", int'(low_force), 0);
        disable_req = 1'b1; ov_above = 1'b1;
        adv(3);
        chk("R7", "latch survives disable and ov", int'(st_latched), 1);
        chk("R7", "latch ignores ov", int'(low_force), 0);
        disable_req = 1'b0; ov_above = 1'b0;
        adv(3);
        chk("R7", "latch survives release", int'(st_latched), 1);
        chk("R7", "no resample while latched", int'(isrc_en), 0);
        supply_ok = 1'b0; adv(1);
        chk("R1", "supply drop clears latch", int'(st_latched), 0);
        supply_ok = 1'b1; adv(1);
        chk("R1", "supply rise resamples", int'(isrc_en), 1);
    endtask

    task automatic t_uv;
        power_up(20, 1'b0);
        uv_trip = 1'b1; adv(1); uv_trip = 1'b0;
        chk("R8", "uv in run latches", int'(st_latched), 1);
        chk("R8", "uv latch switch off", int'(switch_en), 0);
    endtask

    task automatic t_uv_oc_same_cycle;
        power_up(20, 1'b0);
        uv_trip = 1'b1; oc_trip = 1'b1; adv(1);
        uv_trip = 1'b0; oc_trip = 1'b0;
        chk("R8", "uv+oc same cycle latches", int'(st_latched), 1);
        adv(2);
        chk("R8", "no retry ramp after uv+oc", int'(switch_en), 0);
    endtask

    task automatic t_ov;
        power_up(20, 1'b0);
        ov_above = 1'b1; adv(1); ov_above = 1'b0;
        chk("R10", "ov flag set", int'(st_ov), 1);
        chk("R10", "low forced", int'(low_force), 1);
        chk("R10", "switching parked", int'(switch_en), 0);
        adv(5);
        chk("R10", "ov held in hysteresis band", int'(st_ov), 1);
        chk("R10", "ov keeps ready", int'(st_ready), 1);
        ov_below = 1'b1; adv(1); ov_below = 1'b0;
        chk("R10", "ov released", int'(st_ov), 0);
        chk("R10", "switching resumes", int'(switch_en), 1);
        chk("R10", "low force released", int'(low_force), 0);
    endtask

    task automatic t_disable;
        power_up(20, 1'b0);
        disable_req = 1'b1; adv(1);
        chk("R11", "disable stops switching", int'(switch_en), 0);
        chk("R11", "disable zeroes ref", int'(ref_code), 0);
        chk("R11", "disable low off", int'(low_force), 0);
        adv(10);
        chk("R11", "disable holds", int'(switch_en), 0);
        chk("R11", "no sampling while disabled", int'(isrc_en), 0);
        disable_req = 1'b0; adv(1);
        chk("R11", "release starts sampling", int'(isrc_en), 1);
        adv(16);
        chk("R11", "ramp after resample", int'(switch_en), 1);
        adv(520);
        chk("R11", "ready after restart", int'(st_ready), 1);
    endtask

    task automatic t_count_kept;
        power_up(20, 1'b0);
        oc_trip = 1'b1; adv(1); oc_trip = 1'b0;
        adv(521);
        chk("R6", "ready after retry ramp", int'(st_ready), 1);
        disable_req = 1'b1; adv(2);
        disable_req = 1'b0;
        adv(17 + 520);
        chk("R11", "ready after disable cycle", int'(st_ready), 1);
        oc_trip = 1'b1; adv(1); oc_trip = 1'b0;
        chk("R11", "oc count kept across disable", int'(st_latched), 1);
    endtask

    initial begin
        rst = 1'b1; supply_ok = 1'b0; disable_req = 1'b0; sw_tick = 1'b0;
        oc_trip = 1'b0; uv_trip = 1'b0; ov_above = 1'b0; ov_below = 1'b0;
        lvl_code = '0; lvl_open = 1'b0;
        adv(3);
        rst = 1'b0;
        adv(2);
        t_reset();
        t_sample_and_ramp();
        t_clamp();
        t_oc_retry_latch();
        t_uv();
        t_uv_oc_same_cycle();
        t_ov();
        t_disable();
        t_count_kept();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule